// File: doc/BRIEF.md
# Transmit Frame Validator and Launcher

This block starts frame transmission for a simple Ethernet MAC. Software first writes a complete frame into a transmit buffer. The frame includes the eight-byte preamble/SFD at the front and the four-byte FCS at the end. Software then writes the total byte count into a count register. A nonzero count write made while the block is idle starts an attempt.

The block checks the count against a minimum and a maximum. It then reads the first eight buffer bytes and compares them with the preamble/SFD pattern. If both checks pass, the block reads the frame body out of the buffer and streams it on a byte-wide valid/ready interface. The preamble/SFD and the FCS are not sent. A successful send clears the count register. A rejected frame leaves the count untouched. Every attempt, sent or rejected, ends with a one-cycle transmit interrupt pulse.

The buffer read port has one cycle of latency. A two-entry staging queue in front of the stream keeps the output at one byte per cycle while the receiver is ready. When the receiver stalls, the queue holds the bytes so that none is lost.

Top module: `txl_top`

## Requirements
- R1: After reset, `cnt_value` is 0 and `busy`, `out_valid` and `tx_irq` are all 0.
- R2: A write made while `busy` is low always stores `cnt_wr_data` into the count register. If the value is nonzero, `busy` is high in the cycle after the write edge. If the value is zero, the write only stores it: no attempt starts, no interrupt is raised and no byte is emitted.
- R3: A count below MIN_LEN (64) is rejected. No byte is emitted and the count is kept. `tx_irq` is high in the cycle after the first rising edge that follows the write edge.
- R4: A count above MAX_LEN (1530) is rejected in the same way and with the same timing as R3.
- R5: A frame is rejected unless buffer bytes 0 to 6 are 0x55 and byte 7 is 0xD5. On this rejection no byte is emitted and the count is kept. `tx_irq` is high in the cycle after the tenth rising edge that follows the write edge, whichever preamble byte is wrong.
- R6: An accepted frame emits buffer bytes from address 8 up to address count-5, in address order, which is count-12 bytes. `out_last` is 1 on the final byte only. No byte appears while `busy` is low.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R8: After a successful send, `cnt_value` reads 0 and `tx_irq` is high in the cycle right after the edge that accepts the final byte.
- R9: Each started attempt produces exactly one `tx_irq` pulse, and that pulse lasts one cycle.
- R10: A count write made while `busy` is high is ignored. It does not change the count and does not start another attempt.
- R11: With `out_ready` held at 1, the bytes of a frame are accepted on consecutive cycles, so the first and last byte are count-13 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_wr_en | input | 1 | Count register write strobe |
| cnt_wr_data | input | CNT_W | Count value written |
| cnt_value | output | CNT_W | Current count register contents |
| busy | output | 1 | High while an attempt is in progress |
| buf_rd_en | output | 1 | Buffer read request |
| buf_rd_addr | output | ADDR_W | Buffer byte address |
| buf_rd_data | input | 8 | Buffer byte, valid one cycle after the request |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts a byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Marks the final byte of a frame |
| tx_irq | output | 1 | One-cycle pulse at the end of each attempt |

## Verification
The bench builds the block with its default parameters: MIN_LEN 64, MAX_LEN 1530, a 2048-byte buffer and a two-entry staging queue. With these values the exact length boundaries 63, 64, 1530 and 1531 can be tested directly. They also allow a full maximum-length frame with FCS addresses near the top of the buffer. The two-entry queue is the smallest depth that sustains one byte per cycle, so a back-to-back stream also exercises the credit arithmetic at its tightest point.

// File: rtl/txl_pkg.sv
`timescale 1ns/1ps
package txl_pkg;

    // Framing constants of the launched frame
    localparam int PRE_LEN = 8;
    localparam int FCS_LEN = 4;
    localparam logic [7:0] PRE_FILL = 8'h55;
    localparam logic [7:0] PRE_SFD  = 8'hD5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEN,
        ST_PRE,
        ST_SEND
    } txl_state_e;

    typedef struct packed {
        logic       last;
        logic [7:0] data;
    } txl_beat_t;

    // Expected byte at a given preamble/SFD position
    function automatic logic [7:0] pre_expected(input logic [2:0] idx);
        return (idx == 3'd7) ? PRE_SFD : PRE_FILL;
    endfunction

endpackage

// File: rtl/txl_count_reg.sv
`timescale 1ns/1ps
module txl_count_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             idle,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt,
    output logic             start
);

    // Writes land only while idle; a nonzero one launches an attempt
    assign start = wr_en && idle && (wr_data != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wr_en && idle) begin
            cnt <= wr_data;
        end else if (clear) begin
            cnt <= '0;
        end
    end

endmodule

// File: rtl/txl_beat_fifo.sv
`timescale 1ns/1ps
module txl_beat_fifo
    import txl_pkg::*;
#(
    parameter  int DEPTH = 2,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  txl_beat_t din,
    input  logic      pop,
    output txl_beat_t dout,
    output logic      empty,
    output logic [CW-1:0] level
);

    txl_beat_t     slots [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;
    logic [CW-1:0] lvl;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wp] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            lvl <= '0;
        end else begin
            if (push) begin
                wp <= bump(wp);
            end
            if (pop) begin
                rp <= bump(rp);
            end
            lvl <= lvl + CW'(push) - CW'(pop);
        end
    end

    assign dout  = slots[rp];
    assign empty = (lvl == '0);
    assign level = lvl;

endmodule

// File: rtl/txl_seq.sv
`timescale 1ns/1ps
module txl_seq
    import txl_pkg::*;
#(
    parameter  int CNT_W      = 16,
    parameter  int ADDR_W     = 11,
    parameter  int MIN_LEN    = 64,
    parameter  int MAX_LEN    = 1530,
    parameter  int FIFO_DEPTH = 2,
    localparam int CW         = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [7:0]        buf_rd_data,
    input  logic [CW-1:0]     fifo_level,
    input  logic              pop,
    input  logic              pop_last,
    output logic              idle,
    output logic              buf_rd_en,
    output logic [ADDR_W-1:0] buf_rd_addr,
    output logic              push,
    output txl_beat_t         push_beat,
    output logic              done_ok,
    output logic              irq
);

    txl_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              issued_all_q;
    logic              rvalid_q;
    logic              rlast_q;
    logic [2:0]        ridx_q;
    logic              bad_q;
    logic              irq_q;

    logic [CNT_W-1:0]  last_addr;
    logic              len_ok;
    logic              pre_mis;
    logic              pre_done;
    logic              fail_len;
    logic              fail_pre;
    logic              issue_pre;
    logic              issue_send;
    logic              at_last;
    logic [CW:0]       occ_next;

    assign last_addr = cnt - CNT_W'(FCS_LEN + 1);
    assign len_ok    = (cnt >= CNT_W'(MIN_LEN)) && (cnt <= CNT_W'(MAX_LEN));
    assign at_last   = (CNT_W'(addr_q) == last_addr);

    // Queue occupancy seen by a byte requested now when it arrives
    assign occ_next  = {1'b0, fifo_level} + (CW + 1)'(rvalid_q) - (CW + 1)'(pop);

    assign issue_pre  = (state_q == ST_PRE) && (addr_q < ADDR_W'(PRE_LEN));
    assign issue_send = (state_q == ST_SEND) && !issued_all_q
                        && (occ_next < (CW + 1)'(FIFO_DEPTH));

    assign pre_mis  = rvalid_q && (buf_rd_data != pre_expected(ridx_q));
    assign pre_done = (state_q == ST_PRE) && rvalid_q && (ridx_q == 3'd7);
    assign fail_len = (state_q == ST_LEN) && !len_ok;
    assign fail_pre = pre_done && (bad_q || pre_mis);
    assign done_ok  = (state_q == ST_SEND) && pop_last;

    assign idle        = (state_q == ST_IDLE);
    assign buf_rd_en   = issue_pre || issue_send;
    assign buf_rd_addr = addr_q;
    assign push        = rvalid_q && (state_q == ST_SEND);
    assign push_beat   = '{last: rlast_q, data: buf_rd_data};
    assign irq         = irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            addr_q       <= '0;
            issued_all_q <= 1'b0;
            rvalid_q     <= 1'b0;
            rlast_q      <= 1'b0;
            ridx_q       <= '0;
            bad_q        <= 1'b0;
            irq_q        <= 1'b0;
        end else begin
            irq_q    <= fail_len || fail_pre || done_ok;
            rvalid_q <= buf_rd_en;
            ridx_q   <= addr_q[2:0];
            rlast_q  <= issue_send && at_last;

            if (buf_rd_en) begin
                addr_q <= addr_q + 1'b1;
            end
            if (issue_send && at_last) begin
                issued_all_q <= 1'b1;
            end

            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q      <= ST_LEN;
                        addr_q       <= '0;
                        issued_all_q <= 1'b0;
                        bad_q        <= 1'b0;
                    end
                end
                ST_LEN: begin
                    state_q <= len_ok ? ST_PRE : ST_IDLE;
                end
                ST_PRE: begin
                    if (pre_mis) begin
                        bad_q <= 1'b1;
                    end
                    if (pre_done) begin
                        state_q <= fail_pre ? ST_IDLE : ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (pop_last) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/txl_top.sv
`timescale 1ns/1ps
module txl_top
    import txl_pkg::*;
#(
    parameter  int CNT_W      = 16,
    parameter  int BUF_DEPTH  = 2048,
    parameter  int MIN_LEN    = 64,
    parameter  int MAX_LEN    = 1530,
    parameter  int FIFO_DEPTH = 2,
    localparam int ADDR_W     = $clog2(BUF_DEPTH),
    localparam int CW         = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_wr_en,
    input  logic [CNT_W-1:0]  cnt_wr_data,
    output logic [CNT_W-1:0]  cnt_value,
    output logic              busy,
    output logic              buf_rd_en,
    output logic [ADDR_W-1:0] buf_rd_addr,
    input  logic [7:0]        buf_rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last,
    output logic              tx_irq
);

    logic          idle;
    logic          start;
    logic          done_ok;
    logic          push;
    logic          pop;
    logic          pop_last;
    logic          q_empty;
    logic [CW-1:0] q_level;
    txl_beat_t     push_beat;
    txl_beat_t     head;

    txl_count_reg #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cnt_wr_en),
        .wr_data (cnt_wr_data),
        .idle    (idle),
        .clear   (done_ok),
        .cnt     (cnt_value),
        .start   (start)
    );

    txl_seq #(
        .CNT_W      (CNT_W),
        .ADDR_W     (ADDR_W),
        .MIN_LEN    (MIN_LEN),
        .MAX_LEN    (MAX_LEN),
        .FIFO_DEPTH (FIFO_DEPTH)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .cnt         (cnt_value),
        .buf_rd_data (buf_rd_data),
        .fifo_level  (q_level),
        .pop         (pop),
        .pop_last    (pop_last),
        .idle        (idle),
        .buf_rd_en   (buf_rd_en),
        .buf_rd_addr (buf_rd_addr),
        .push        (push),
        .push_beat   (push_beat),
        .done_ok     (done_ok),
        .irq         (tx_irq)
    );

    txl_beat_fifo #(.DEPTH(FIFO_DEPTH)) u_q (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (push_beat),
        .pop   (pop),
        .dout  (head),
        .empty (q_empty),
        .level (q_level)
    );

    assign out_valid = !q_empty;
    assign out_data  = head.data;
    assign out_last  = head.last;
    assign pop       = out_valid && out_ready;
    assign pop_last  = pop && head.last;
    assign busy      = !idle;

endmodule

// File: rtl/txl_chk.sv
`timescale 1ns/1ps
module txl_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_wr_en,
    input logic [CNT_W-1:0] cnt_wr_data,
    input logic [CNT_W-1:0] cnt_value,
    input logic             busy,
    input logic             buf_rd_en,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             out_last,
    input logic             tx_irq
);

    // R9: interrupt is a single-cycle pulse
    a_r9_irq_single: assert property (@(posedge clk) disable iff (rst)
        tx_irq |=> !tx_irq);

    // R7: stalled byte is held unchanged
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R8: final byte acceptance clears the count and raises the interrupt
    a_r8_clear_and_irq: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (tx_irq && cnt_value == '0));

    // R10: writes while busy leave the count alone
    a_r10_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt_wr_en && !(out_valid && out_ready && out_last)) |=> $stable(cnt_value));

    // R6: no stream or buffer traffic while idle
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!out_valid && !buf_rd_en));

    // R2: an attempt only begins with a nonzero count
    a_r2_start_nonzero: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (cnt_value != '0));

    // R2: a zero write while idle starts nothing
    a_r2_zero_no_start: assert property (@(posedge clk) disable iff (rst)
        (!busy && cnt_wr_en && cnt_wr_data == '0) |=> !busy);

endmodule

bind txl_top txl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/txl_top_test.sv
`timescale 1ns/1ps
module txl_top_test;

    localparam int CNT_W  = 16;
    localparam int ADDR_W = 11;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cnt_wr_en = 1'b0;
    logic [CNT_W-1:0]  cnt_wr_data = '0;
    logic [CNT_W-1:0]  cnt_value;
    logic              busy;
    logic              buf_rd_en;
    logic [ADDR_W-1:0] buf_rd_addr;
    logic [7:0]        buf_rd_data = 8'h00;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [7:0]        out_data;
    logic              out_last;
    logic              tx_irq;

    always #2.5 clk = ~clk;

    txl_top uut (
        .clk(clk), .rst(rst),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data), .cnt_value(cnt_value),
        .busy(busy),
        .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .tx_irq(tx_irq)
    );

    // Buffer model: synchronous read, one cycle of latency
    logic [7:0] mem [0:2047];
    always @(posedge clk) begin
        if (buf_rd_en) buf_rd_data <= mem[buf_rd_addr];
    end

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference state
    logic [8:0] exp_q [$];
    int  irq_cnt = 0;
    int  cyc = 0;
    int  first_hs = -1;
    int  last_hs = -1;
    bit  exp_irq_next = 0;
    bit  prev_irq = 0, prev_v = 0, prev_r = 0, prev_l = 0;
    logic [7:0] prev_d = 8'h00;
    int  ready_mode = 0;
    int  rcyc = 0;

    // Downstream ready pattern, changed away from the active edge
    always @(negedge clk) begin
        rcyc++;
        if (ready_mode == 0) out_ready = 1'b1;
        else out_ready = (((rcyc * 5) % 7) < 4);
    end

    // Cycle-by-cycle comparison against the reference queue
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            cyc++;
            if (exp_irq_next) begin
                chk(tx_irq == 1'b1, "R8 irq after last byte", int'(tx_irq), 1);
                chk(cnt_value == '0, "R8 count cleared", int'(cnt_value), 0);
                exp_irq_next = 0;
            end
            if (tx_irq) begin
                irq_cnt++;
                chk(!prev_irq, "R9 pulse width", 2, 1);
            end
            if (prev_v && !prev_r) begin
                chk(out_valid && out_data == prev_d && out_last == prev_l,
                    "R7 held on stall", int'(out_data), int'(prev_d));
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected byte", int'(out_data), -1);
                end else begin
                    logic [8:0] beat;
                    beat = exp_q.pop_front();
                    chk({out_last, out_data} == beat, "R6 byte/last",
                        int'({out_last, out_data}), int'(beat));
                    if (out_last) exp_irq_next = 1;
                    if (first_hs < 0) first_hs = cyc;
                    last_hs = cyc;
                end
            end
            prev_v   = out_valid;
            prev_r   = out_ready;
            prev_d   = out_data;
            prev_l   = out_last;
            prev_irq = tx_irq;
        end
    end

    task automatic load_frame(input int n, input int bad_idx);
        for (int i = 0; i < 2048; i++) mem[i] = 8'((i * 7 + n) & 255);
        for (int i = 0; i < 7; i++) mem[i] = 8'h55;
        mem[7] = 8'hD5;
        if (bad_idx >= 0) mem[bad_idx] = (bad_idx == 7) ? 8'h55 : 8'h54;
    endtask

    task automatic reject(input int n, input int bad_idx, input int lat, input string tag);
        int base;
        int k;
        load_frame(n, bad_idx);
        base = irq_cnt;
        @(negedge clk); cnt_wr_en = 1'b1; cnt_wr_data = CNT_W'(n);
        @(negedge clk); cnt_wr_en = 1'b0; #1;
        chk(busy, {tag, " busy after start (R2)"}, int'(busy), 1);
        k = 0;
        while (!tx_irq && k < 40) begin
            @(negedge clk); #1; k++;
        end
        chk(k == lat, {tag, " irq latency"}, k, lat);
        chk(cnt_value == CNT_W'(n), {tag, " count kept"}, int'(cnt_value), n);
        repeat (3) @(negedge clk);
        #1;
        chk(irq_cnt == base + 1, {tag, " one irq (R9)"}, irq_cnt - base, 1);
        chk(!busy, {tag, " idle after"}, int'(busy), 0);
    endtask

    task automatic send_frame(input int n, input int mode, input bit inject);
        int base;
        int t;
        ready_mode = mode;
        load_frame(n, -1);
        for (int a = 8; a <= n - 5; a++) exp_q.push_back({(a == n - 5), mem[a]});
        base = irq_cnt;
        first_hs = -1;
        @(negedge clk); cnt_wr_en = 1'b1; cnt_wr_data = CNT_W'(n);
        @(negedge clk); cnt_wr_en = 1'b0; #1;
        chk(busy, "R2 busy after nonzero write", int'(busy), 1);
        if (inject) begin
            repeat (20) @(negedge clk);
            cnt_wr_en = 1'b1; cnt_wr_data = 16'd100;
            @(negedge clk); cnt_wr_en = 1'b0;
        end
        t = 0;
        while ((exp_q.size() != 0 || busy) && t < 20000) begin
            @(negedge clk); t++;
        end
        repeat (3) @(negedge clk);
        #1;
        chk(exp_q.size() == 0, "R6 all bytes emitted", exp_q.size(), 0);
        chk(cnt_value == '0, "R8 count zero after send", int'(cnt_value), 0);
        chk(irq_cnt == base + 1, "R9 one irq per send", irq_cnt - base, 1);
        chk(!busy, "R6 idle after send", int'(busy), 0);
        if (mode == 0) chk(last_hs - first_hs == n - 13, "R11 back-to-back",
                           last_hs - first_hs, n - 13);
        if (inject) begin
            repeat (30) @(negedge clk);
            #1;
            chk(irq_cnt == base + 1 && !busy, "R10 no second attempt", irq_cnt - base, 1);
            chk(cnt_value == '0, "R10 count untouched by busy write", int'(cnt_value), 0);
        end
    endtask

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(cnt_value == '0, "R1 count", int'(cnt_value), 0);
        chk(!busy, "R1 busy", int'(busy), 0);
        chk(!out_valid, "R1 out_valid", int'(out_valid), 0);
        chk(!tx_irq, "R1 tx_irq", int'(tx_irq), 0);

        reject(63, -1, 1, "R3 short");
        base = irq_cnt;
        @(negedge clk); cnt_wr_en = 1'b1; cnt_wr_data = '0;
        @(negedge clk); cnt_wr_en = 1'b0;
        repeat (5) @(negedge clk);
        #1;
        chk(cnt_value == '0, "R2 zero stored", int'(cnt_value), 0);
        chk(irq_cnt == base, "R2 zero no irq", irq_cnt - base, 0);
        chk(!busy, "R2 zero no start", int'(busy), 0);

        reject(1531, -1, 1, "R4 long");
        reject(100, 0, 10, "R5 bad byte0");
        reject(100, 3, 10, "R5 bad byte3");
        reject(100, 7, 10, "R5 bad sfd");

        send_frame(64, 0, 0);
        send_frame(1530, 0, 0);
        send_frame(100, 1, 0);
        send_frame(65, 1, 0);
        send_frame(200, 1, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        finished = 1;
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule